// File: doc/BRIEF.md
# Multi-Speed Fiber Link Bring-Up Sequencer

This block brings up a fiber link whose optics cannot negotiate a line rate on their own. After a start pulse it limits the requested speeds to the ones the port supports. It then works through the remaining speeds one at a time, the faster rate first. For each speed it programs the rate-select bit of the optical module, waits for the analog front end to settle, and asks the MAC to set up that speed. It then pulses a laser-flap request and watches the link status for a bounded window.

The attempt ends in one of three ways: the link comes up, every speed has failed, or the MAC setup handshake reports an error. If no link came up and more than one speed was attempted, the sequencer makes one extra attempt at the fastest speed it tried. At the end it reports a status code and an advertised-speed mask. Time is counted in milliseconds taken from an internal prescaler. The module register bus and the MAC are outside the block and are reached through request/acknowledge pairs.

Top module: `fiber_speed_seq`

## Requirements
- R1: Only speeds present in both `req_mask` and `cap_mask` are attempted; an empty intersection ends the run with no module write and no MAC setup, status 1. Speed masks use bit 1 for 10G and bit 0 for 1G.
- R2: When both speeds survive, 10G is attempted before 1G.
- R3: If `link_up` is high and `link_speed` equals the speed about to be attempted, the run ends at once with status 0, without a module write or a MAC setup.
- R4: Each attempt writes the rate-select bit twice: first with `mod_wr_sel`=0, then with `mod_wr_sel`=1. Each write is held until `mod_wr_ack`. `mod_rate` is 1 for 10G and 0 for 1G.
- R5: `mac_setup_req` rises SETTLE_MS milliseconds after the acknowledge of the second module write.
- R6: Every accepted MAC setup (`mac_setup_done` with `mac_setup_err` low) is followed by exactly one single-cycle `flap_req`.
- R7: After a 10G setup, the link is checked every POLL_MS milliseconds, at most POLLS_HI times (default 5). The run ends with status 0 at the first check that sees `link_up`.
- R8: After a 1G setup there is a single POLL_MS wait followed by one link check.
- R9: If no link was found and more than one speed was attempted, one extra pass at the fastest attempted speed is made. There is never a second extra pass, and there is none when only one speed was attempted. A failed run ends with status 1.
- R10: On a run that ends with status 0 or 1, `adv_mask` becomes `req_mask & cap_mask`.
- R11: `mac_setup_done` together with `mac_setup_err` aborts the run with status 2, with no flap, and leaves `adv_mask` unchanged.
- R12: `start` is ignored while `busy` is high.
- R13: After reset `busy`, `done`, all requests, `adv_mask` and `status` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up run (taken only when idle) |
| req_mask | input | 2 | Requested speeds, bit1 = 10G, bit0 = 1G |
| cap_mask | input | 2 | Speeds the port supports |
| link_up | input | 1 | Link status |
| link_speed | input | 2 | Current link speed, one-hot like the masks |
| mod_wr_req | output | 1 | Module rate-select write request |
| mod_wr_sel | output | 1 | Which module control byte: 0 first, 1 second |
| mod_rate | output | 1 | Rate-select value, 1 = 10G |
| mod_wr_ack | input | 1 | Module write acknowledge |
| mac_setup_req | output | 1 | MAC speed setup request |
| mac_setup_speed | output | 2 | One-hot speed for the MAC setup |
| mac_setup_done | input | 1 | MAC setup complete |
| mac_setup_err | input | 1 | MAC setup failed, valid with done |
| flap_req | output | 1 | Single-cycle laser flap request |
| busy | output | 1 | Run in progress |
| done | output | 1 | Single-cycle end-of-run pulse |
| adv_mask | output | 2 | Advertised speeds |
| status | output | 2 | 0 link up, 1 no link, 2 MAC error |

## Verification
Each run is made against a link-partner model that comes up only at chosen speeds and after a chosen delay. The cases are: a partner already up at 10G, a partner that answers on the third 10G poll, a partner that answers only at 1G, and no partner at all. Together these separate an immediate exit, an exit in the middle of polling, a fall-through to the slower speed, and a single fallback pass. A supported mask of 1G only shows both the masking and the absence of a retry after a single attempt. An erroring MAC shows the abort path and that the advertised mask is left alone. A second start with a different mask during a run shows that it is ignored. The settle delay and the two poll windows are measured in cycles from the module acknowledges and the flaps.

// File: rtl/fiber_speed_seq.sv
module fiber_speed_seq #(
  parameter int TICK_DIV  = 125000,
  parameter int SETTLE_MS = 40,
  parameter int POLL_MS   = 100,
  parameter int POLLS_HI  = 5,
  parameter int POLLS_LO  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] req_mask,
  input  logic [1:0] cap_mask,
  input  logic       link_up,
  input  logic [1:0] link_speed,
  output logic       mod_wr_req,
  output logic       mod_wr_sel,
  output logic       mod_rate,
  input  logic       mod_wr_ack,
  output logic       mac_setup_req,
  output logic [1:0] mac_setup_speed,
  input  logic       mac_setup_done,
  input  logic       mac_setup_err,
  output logic       flap_req,
  output logic       busy,
  output logic       done,
  output logic [1:0] adv_mask,
  output logic [1:0] status
);
  localparam int MS_MAX = (SETTLE_MS > POLL_MS) ? SETTLE_MS : POLL_MS;
  localparam int P_MAX  = (POLLS_HI > POLLS_LO) ? POLLS_HI : POLLS_LO;
  localparam int PW     = $clog2(TICK_DIV + 1);
  localparam int MW     = $clog2(MS_MAX + 1);
  localparam int CW     = $clog2(P_MAX + 1);
  localparam logic [1:0] SPD_HI = 2'b10;
  localparam logic [1:0] SPD_LO = 2'b01;
  localparam logic [1:0] ST_OK = 2'd0, ST_NOLINK = 2'd1, ST_ERR = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_PICK, S_WR0, S_WR1, S_SETTLE, S_MAC, S_FLAP, S_WAIT, S_POLL, S_END
  } st_t;

  st_t           st;
  logic [1:0]    eff_q, todo_q, first_q, ntried_q;
  logic          cur_hi, retry_q;
  logic [PW-1:0] pre_q;
  logic [MW-1:0] ms_q;
  logic [CW-1:0] poll_q;
  logic [1:0]    status_q, adv_q;

  wire           tick     = (pre_q == PW'(TICK_DIV - 1));
  wire           expired  = tick && (ms_q == MW'(1));
  wire           pick_hi  = todo_q[1];
  wire [1:0]     pick_spd = pick_hi ? SPD_HI : SPD_LO;
  wire [CW-1:0]  poll_lim = cur_hi ? CW'(POLLS_HI) : CW'(POLLS_LO);
  wire           last_poll = ({1'b0, poll_q} + 1'b1) >= {1'b0, poll_lim};

  assign busy            = (st != S_IDLE);
  assign done            = (st == S_END);
  assign mod_wr_req      = (st == S_WR0) || (st == S_WR1);
  assign mod_wr_sel      = (st == S_WR1);
  assign mod_rate        = cur_hi;
  assign mac_setup_req   = (st == S_MAC);
  assign mac_setup_speed = cur_hi ? SPD_HI : SPD_LO;
  assign flap_req        = (st == S_FLAP);
  assign adv_mask        = adv_q;
  assign status          = status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      eff_q    <= '0;
      todo_q   <= '0;
      first_q  <= '0;
      ntried_q <= '0;
      cur_hi   <= 1'b0;
      retry_q  <= 1'b0;
      pre_q    <= '0;
      ms_q     <= '0;
      poll_q   <= '0;
      status_q <= ST_OK;
      adv_q    <= '0;
    end else begin
      if (st == S_SETTLE || st == S_WAIT) begin
        if (tick) begin
          pre_q <= '0;
          ms_q  <= ms_q - 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
      case (st)
        S_IDLE: if (start) begin
          eff_q    <= req_mask & cap_mask;
          todo_q   <= req_mask & cap_mask;
          first_q  <= '0;
          ntried_q <= '0;
          retry_q  <= 1'b0;
          st       <= S_PICK;
        end
        S_PICK: begin
          if (todo_q != 2'b00) begin
            todo_q   <= todo_q & ~pick_spd;
            cur_hi   <= pick_hi;
            ntried_q <= ntried_q + 1'b1;
            if (first_q == 2'b00) first_q <= pick_spd;
            if (link_up && link_speed == pick_spd) begin
              status_q <= ST_OK;
              adv_q    <= eff_q;
              st       <= S_END;
            end else begin
              st <= S_WR0;
            end
          end else if (ntried_q > 2'd1 && !retry_q) begin
            todo_q   <= first_q;
            first_q  <= '0;
            ntried_q <= '0;
            retry_q  <= 1'b1;
          end else begin
            status_q <= ST_NOLINK;
            adv_q    <= eff_q;
            st       <= S_END;
          end
        end
        S_WR0: if (mod_wr_ack) st <= S_WR1;
        S_WR1: if (mod_wr_ack) begin
          st    <= S_SETTLE;
          pre_q <= '0;
          ms_q  <= MW'(SETTLE_MS);
        end
        S_SETTLE: if (expired) st <= S_MAC;
        S_MAC: if (mac_setup_done) begin
          if (mac_setup_err) begin
            status_q <= ST_ERR;
            st       <= S_END;
          end else begin
            st <= S_FLAP;
          end
        end
        S_FLAP: begin
          st     <= S_WAIT;
          pre_q  <= '0;
          ms_q   <= MW'(POLL_MS);
          poll_q <= '0;
        end
        S_WAIT: if (expired) st <= S_POLL;
        S_POLL: begin
          if (link_up) begin
            status_q <= ST_OK;
            adv_q    <= eff_q;
            st       <= S_END;
          end else if (last_poll) begin
            st <= S_PICK;
          end else begin
            poll_q <= poll_q + 1'b1;
            pre_q  <= '0;
            ms_q   <= MW'(POLL_MS);
            st     <= S_WAIT;
          end
        end
        S_END: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SPEED_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    mac_setup_req |-> ((mac_setup_speed & ~eff_q) == 2'b00)); // R1
  AST_SECOND_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_wr_req && mod_wr_sel) |-> $past(mod_wr_req)); // R4
  AST_FLAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flap_req |=> !flap_req); // R6
  AST_FLAP_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    flap_req |-> $past(mac_setup_req && mac_setup_done && !mac_setup_err)); // R6
  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_setup_req && mac_setup_done && mac_setup_err) |=> (done && status == ST_ERR && !flap_req)); // R11
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R12
endmodule

// File: tb/fiber_speed_seq_tb_top.sv
module fiber_speed_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 2, SET = 40, PMS = 100, NP = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] req_mask = '0, cap_mask = '0, link_speed;
  logic link_up, mod_wr_req, mod_wr_sel, mod_rate, mod_wr_ack;
  logic mac_setup_req, mac_setup_done, mac_setup_err, flap_req, busy, done;
  logic [1:0] mac_setup_speed, adv_mask, status;

  int checks = 0, errors = 0, cyc = 0;
  int wr_n, mac_n, flap_n, link_cnt, link_delay, gap_min, gap_max;
  logic [1:0] wr_log [16];
  int wr_cyc [16];
  logic [1:0] mac_log [8];
  int flap_cyc [8];
  logic [1:0] partner, pend_spd;
  logic mac_err_mode, mac_prev;
  logic [1:0] res_status, res_adv;

  always #(CLK_PERIOD/2) clk = ~clk;

  fiber_speed_seq #(.TICK_DIV(DIV), .SETTLE_MS(SET), .POLL_MS(PMS), .POLLS_HI(NP), .POLLS_LO(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .req_mask(req_mask), .cap_mask(cap_mask),
    .link_up(link_up), .link_speed(link_speed), .mod_wr_req(mod_wr_req), .mod_wr_sel(mod_wr_sel),
    .mod_rate(mod_rate), .mod_wr_ack(mod_wr_ack), .mac_setup_req(mac_setup_req),
    .mac_setup_speed(mac_setup_speed), .mac_setup_done(mac_setup_done), .mac_setup_err(mac_setup_err),
    .flap_req(flap_req), .busy(busy), .done(done), .adv_mask(adv_mask), .status(status));

  initial begin
    mod_wr_ack = 0; mac_setup_done = 0; mac_setup_err = 0; link_up = 0; link_speed = 0;
    mac_err_mode = 0; mac_prev = 0; partner = 0; link_cnt = 0; link_delay = 0; pend_spd = 0;
    wr_n = 0; mac_n = 0; flap_n = 0; gap_min = 1 << 30; gap_max = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (mod_wr_req && mod_wr_ack && wr_n < 16) begin
        wr_log[wr_n] = {mod_wr_sel, mod_rate}; wr_cyc[wr_n] = cyc; wr_n++;
      end
      mod_wr_ack <= mod_wr_req && !mod_wr_ack;
      if (mac_setup_req && !mac_prev && wr_n > 0) begin
        if (cyc - wr_cyc[wr_n-1] < gap_min) gap_min = cyc - wr_cyc[wr_n-1];
        if (cyc - wr_cyc[wr_n-1] > gap_max) gap_max = cyc - wr_cyc[wr_n-1];
      end
      mac_prev = mac_setup_req;
      if (mac_setup_req && mac_setup_done && mac_n < 8) begin
        mac_log[mac_n] = mac_setup_speed; mac_n++;
      end
      mac_setup_done <= mac_setup_req && !mac_setup_done;
      mac_setup_err  <= mac_err_mode;
      if (flap_req && flap_n < 8 && mac_n > 0) begin
        flap_cyc[flap_n] = cyc; flap_n++;
        if ((mac_log[mac_n-1] & partner) != 0) begin
          link_cnt = link_delay; pend_spd = mac_log[mac_n-1];
        end
      end
      if (link_cnt > 0) begin
        link_cnt--;
        if (link_cnt == 0) begin link_up <= 1'b1; link_speed <= pend_spd; end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_range(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic setup_env(input logic [1:0] p, input int dly, input logic [1:0] pre_up);
    @(negedge clk);
    wr_n = 0; mac_n = 0; flap_n = 0; link_cnt = 0; gap_min = 1 << 30; gap_max = 0;
    partner = p; link_delay = dly;
    link_up = (pre_up != 0); link_speed = pre_up;
  endtask

  task automatic run_seq(input logic [1:0] rq, input logic [1:0] cp);
    int n;
    @(negedge clk);
    req_mask = rq; cap_mask = cp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check("run end reached", int'(done), 1);
    res_status = status; res_adv = adv_mask;
  endtask

  task automatic t_reset;
    check("R13 busy after reset", int'(busy), 0);
    check("R13 done after reset", int'(done), 0);
    check("R13 requests after reset", int'({mod_wr_req, mac_setup_req, flap_req}), 0);
    check("R13 adv after reset", int'(adv_mask), 0);
    check("R13 status after reset", int'(status), 0);
  endtask

  task automatic t_already_up;
    setup_env(2'b00, 0, 2'b10);
    run_seq(2'b11, 2'b11);
    check("R3 status", int'(res_status), 0);
    check("R3 no module writes", wr_n, 0);
    check("R3 no mac setup", mac_n, 0);
    check("R10 adv after early exit", int'(res_adv), 3);
  endtask

  task automatic t_link_10g;
    setup_env(2'b10, PMS*DIV*2 + 50, 2'b00);
    run_seq(2'b11, 2'b11);
    check("R7 status link at 10G", int'(res_status), 0);
    check("R2 one setup", mac_n, 1);
    check("R2 first speed is 10G", int'(mac_log[0]), 2);
    check("R4 two writes", wr_n, 2);
    check("R4 first write sel0 rate1", int'(wr_log[0]), 1);
    check("R4 second write sel1 rate1", int'(wr_log[1]), 3);
    check_range("R5 settle cycles", gap_min, SET*DIV, SET*DIV + 3);
    check("R6 one flap", flap_n, 1);
    check("R10 adv", int'(res_adv), 3);
  endtask

  task automatic t_link_1g;
    setup_env(2'b01, 50, 2'b00);
    run_seq(2'b11, 2'b11);
    check("R7 status link at 1G", int'(res_status), 0);
    check("R2 two setups", mac_n, 2);
    check("R2 order 10G then 1G", int'({mac_log[0], mac_log[1]}), 4'b1001);
    check("R4 1G writes rate0", int'({wr_log[2], wr_log[3]}), 4'b0010);
    check_range("R7 10G poll window", wr_cyc[2] - flap_cyc[0], NP*PMS*DIV, NP*PMS*DIV + 2*NP + 10);
    check_range("R5 settle both speeds", gap_max, SET*DIV, SET*DIV + 3);
  endtask

  task automatic t_no_link;
    setup_env(2'b00, 0, 2'b00);
    run_seq(2'b11, 2'b11);
    check("R9 status no link", int'(res_status), 1);
    check("R9 three setups", mac_n, 3);
    check("R9 retry at 10G", int'(mac_log[2]), 2);
    check_range("R8 1G single wait", wr_cyc[4] - flap_cyc[1], PMS*DIV, PMS*DIV + 20);
    check("R6 flaps match setups", flap_n, 3);
    check("R10 adv on failure", int'(res_adv), 3);
  endtask

  task automatic t_cap_only_1g;
    setup_env(2'b00, 0, 2'b00);
    run_seq(2'b11, 2'b01);
    check("R1 single setup", mac_n, 1);
    check("R1 only 1G tried", int'(mac_log[0]), 1);
    check("R9 no retry after one speed", int'(res_status), 1);
    check("R10 adv masked", int'(res_adv), 1);
  endtask

  task automatic t_mac_err;
    setup_env(2'b10, 10, 2'b00);
    mac_err_mode = 1'b1;
    run_seq(2'b11, 2'b11);
    mac_err_mode = 1'b0;
    check("R11 status error", int'(res_status), 2);
    check("R11 one setup", mac_n, 1);
    check("R11 no flap", flap_n, 0);
    check("R11 adv unchanged", int'(res_adv), 1);
  endtask

  task automatic t_empty;
    setup_env(2'b00, 0, 2'b00);
    run_seq(2'b10, 2'b01);
    check("R1 empty status", int'(res_status), 1);
    check("R1 empty no writes", wr_n, 0);
    check("R1 empty adv", int'(res_adv), 0);
  endtask

  task automatic t_start_busy;
    int n;
    setup_env(2'b10, PMS*DIV + 30, 2'b00);
    @(negedge clk);
    req_mask = 2'b11; cap_mask = 2'b11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    req_mask = 2'b01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    check("R12 status", int'(status), 0);
    check("R12 adv from first start", int'(adv_mask), 3);
    repeat (50) @(negedge clk);
    check("R12 idle afterwards", int'(busy), 0);
    check("R12 no extra setup", mac_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_already_up;
    t_link_10g;
    t_link_1g;
    t_no_link;
    t_cap_only_1g;
    t_mac_err;
    t_empty;
    t_start_busy;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule